// File: doc/BRIEF.md
# Phased Segmented Serial Shift Register

This block is a long serial-in shift register whose length is split into four-bit segments. A single shift request does not move every bit on one shared clock edge. A small sequencer instead walks through five update phases, one clock cycle each, and raises exactly one update strobe per phase. Every segment receives the same five strobes. The phases run against the data flow:

1. A holding stage in each segment first copies that segment's last data stage.
2. The four data stages then update from the last to the first.

Each stage therefore captures a value that has already settled. The first data stage of each later segment is fed from the holding stage of the segment before it, and that holding stage carries the bit across the boundary. The last segment has no holding stage, because nothing follows it.

A client raises `shift_req` while `busy` is low and holds `ser_in` stable until `busy` falls. Once the sequence ends, the whole register has moved one place. The newest bit sits in `par_out[0]`, and the bit taken in N shifts earlier appears on `ser_out`.

The sequencer has six named states:

| State | Strobe raised | Next state |
|---|---|---|
| `PH_IDLE` | none | `PH_HOLD` when a request arrives, otherwise `PH_IDLE` |
| `PH_HOLD` | holding stage | `PH_D3` |
| `PH_D3` | fourth data stage | `PH_D2` |
| `PH_D2` | third data stage | `PH_D1` |
| `PH_D1` | second data stage | `PH_D0` |
| `PH_D0` | first data stage | `PH_IDLE` |

Storage is enable-gated registers on one clock.

Top module: `phseg_shifter`

## Requirements
- R1: Synchronous reset `rst` (active high) clears every data stage and holding stage to 0, returns the sequencer to `PH_IDLE` and drives `busy` to 0.
- R2: A `shift_req` sampled high while `busy` is 0 makes `busy` read 1 from the next cycle for exactly five cycles, after which `busy` returns to 0.
- R3: A `shift_req` sampled while `busy` is 1 is ignored. It does not lengthen the busy period, and it does not cause an additional shift.
- R4: At most one of the five update strobes is active in any cycle. They fire in the order holding stage, fourth, third, second and first data stage, one per cycle.
- R5: The first data stage of segment 0 (`par_out[0]`) takes the value of `ser_in` present in the last busy cycle.
- R6: After K completed shifts, `par_out[i]` equals the serial input bit of shift K-i for i < K, and 0 where fewer shifts have happened. Bit index 4s+j is data stage j of segment s.
- R7: A bit crosses each segment boundary (from `par_out[4s+3]` to `par_out[4s+4]`) in a single shift, without loss or duplication.
- R8: `ser_out` equals `par_out[N-1]`, the bit taken in N shifts earlier.
- R9: While `busy` is 0, `par_out` and `ser_out` do not change, whatever `ser_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_req | input | 1 | Request one shift; taken only when idle |
| ser_in | input | 1 | Serial data in; hold until busy falls |
| busy | output | 1 | High during the five update phases |
| par_out | output | N | All data stages, bit 0 the newest |
| ser_out | output | 1 | Last data stage of the last segment |

## Verification
Every cycle, the bound checker confirms the following:
- no two strobes overlap, and they keep their fixed order;
- a request taken while idle starts the holding phase;
- the first-data-stage phase always ends the busy period;
- the first stage captures the serial input;
- nothing moves while idle.

Whether the whole register holds the right history needs the bench's scenarios: multi-bit patterns, a single one walked across segment boundaries to the serial output, requests held through a busy period, and a reset in the middle of a run. These are compared against a reference shift model.

// File: rtl/phseg_pkg.sv
package phseg_pkg;
    localparam int SEG_BITS = 4;
    localparam int NUM_STB  = SEG_BITS + 1;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HOLD = 3'd1,
        PH_D3   = 3'd2,
        PH_D2   = 3'd3,
        PH_D1   = 3'd4,
        PH_D0   = 3'd5
    } phase_e;
endpackage

// File: rtl/phseg_sequencer.sv
module phseg_sequencer
    import phseg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_req,
    output logic               busy,
    output logic [NUM_STB-1:0] stb
);
    phase_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= PH_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE: if (shift_req) state_nx = PH_HOLD;
            PH_HOLD: state_nx = PH_D3;
            PH_D3:   state_nx = PH_D2;
            PH_D2:   state_nx = PH_D1;
            PH_D1:   state_nx = PH_D0;
            PH_D0:   state_nx = PH_IDLE;
            default: state_nx = PH_IDLE;
        endcase
    end

    // stb[j] strobes data stage j; stb[SEG_BITS] strobes the holding stage
    always_comb begin
        stb  = '0;
        busy = 1'b1;
        unique case (state)
            PH_IDLE: busy = 1'b0;
            PH_HOLD: stb[SEG_BITS] = 1'b1;
            PH_D3:   stb[3] = 1'b1;
            PH_D2:   stb[2] = 1'b1;
            PH_D1:   stb[1] = 1'b1;
            PH_D0:   stb[0] = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/phseg_segment.sv
module phseg_segment
    import phseg_pkg::*;
#(
    parameter bit HAS_HOLD = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_STB-1:0]  stb,
    input  logic                seg_in,
    output logic [SEG_BITS-1:0] q,
    output logic                link_out
);
    logic [SEG_BITS-1:0] d_next;
    assign d_next = {q[SEG_BITS-2:0], seg_in};

    for (genvar k = 0; k < SEG_BITS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         q[k] <= 1'b0;
            else if (stb[k]) q[k] <= d_next[k];
        end
    end

    if (HAS_HOLD) begin : g_hold
        logic hold_q;
        always_ff @(posedge clk) begin
            if (rst)                hold_q <= 1'b0;
            else if (stb[SEG_BITS]) hold_q <= q[SEG_BITS-1];
        end
        assign link_out = hold_q;
    end else begin : g_tail
        assign link_out = q[SEG_BITS-1];
    end
endmodule

// File: rtl/phseg_shifter.sv
module phseg_shifter
    import phseg_pkg::*;
#(
    parameter int N = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_req,
    input  logic         ser_in,
    output logic         busy,
    output logic [N-1:0] par_out,
    output logic         ser_out
);
    localparam int NSEG = N / SEG_BITS;

    initial begin
        if (N % SEG_BITS != 0 || N < SEG_BITS)
            $error("phseg_shifter: N must be a positive multiple of %0d", SEG_BITS);
    end

    logic [NUM_STB-1:0] stb;
    logic [NSEG:0]      link;

    phseg_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .shift_req (shift_req),
        .busy      (busy),
        .stb       (stb)
    );

    assign link[0] = ser_in;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        phseg_segment #(.HAS_HOLD(s != NSEG - 1)) u_seg (
            .clk      (clk),
            .rst      (rst),
            .stb      (stb),
            .seg_in   (link[s]),
            .q        (par_out[s*SEG_BITS +: SEG_BITS]),
            .link_out (link[s+1])
        );
    end

    assign ser_out = link[NSEG];
endmodule

// File: rtl/phseg_checker.sv
module phseg_checker
    import phseg_pkg::*;
#(
    parameter int N = 256
) (
    input logic               clk,
    input logic               rst,
    input logic               shift_req,
    input logic               ser_in,
    input logic               busy,
    input logic [N-1:0]       par_out,
    input logic               ser_out,
    input logic [NUM_STB-1:0] stb
);
    assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

    assert_hold_then_d3_R4: assert property (@(posedge clk) disable iff (rst)
        stb[SEG_BITS] |=> stb[3]);
    assert_d3_then_d2_R4: assert property (@(posedge clk) disable iff (rst)
        stb[3] |=> stb[2]);
    assert_d2_then_d1_R4: assert property (@(posedge clk) disable iff (rst)
        stb[2] |=> stb[1]);
    assert_d1_then_d0_R4: assert property (@(posedge clk) disable iff (rst)
        stb[1] |=> stb[0]);

    assert_start_on_request_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && shift_req) |=> (busy && stb[SEG_BITS]));

    assert_end_after_first_stage_R3: assert property (@(posedge clk) disable iff (rst)
        stb[0] |=> !busy);

    assert_first_stage_capture_R5: assert property (@(posedge clk) disable iff (rst)
        stb[0] |=> (par_out[0] == $past(ser_in)));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(par_out) && $stable(ser_out)));
endmodule

bind phseg_shifter phseg_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_req (shift_req),
    .ser_in    (ser_in),
    .busy      (busy),
    .par_out   (par_out),
    .ser_out   (ser_out),
    .stb       (stb)
);

// File: tb/phseg_shifter_test.sv
`timescale 1ns/1ps
module phseg_shifter_test;
    localparam int N = 256;
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'hA5C3, 16'h0000, 16'hFFFF,
                                           16'h8001, 16'h1234, 16'hF0F0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         shift_req = 1'b0;
    logic         ser_in = 1'b0;
    logic         busy;
    logic [N-1:0] par_out;
    logic         ser_out;

    logic [N-1:0] model = '0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    phseg_shifter #(.N(N)) uut (
        .clk       (clk),
        .rst       (rst),
        .shift_req (shift_req),
        .ser_in    (ser_in),
        .busy      (busy),
        .par_out   (par_out),
        .ser_out   (ser_out)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one shift: request at a negedge, hold ser_in until busy falls
    task automatic do_shift(input logic b, input int extra_req, output int busy_cycles);
        @(negedge clk);
        shift_req = 1'b1;
        ser_in    = b;
        busy_cycles = 0;
        @(negedge clk);
        for (int i = 0; i < extra_req; i++) begin
            if (busy) busy_cycles++;
            @(negedge clk);
        end
        shift_req = 1'b0;
        while (busy && busy_cycles < 20) begin
            busy_cycles++;
            @(negedge clk);
        end
        model = {model[N-2:0], b};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
    endtask

    initial begin
        int bc;
        logic [N-1:0] snap;
        logic snap_so;

        do_reset();
        // R1: reset state
        check(par_out == '0, "R1 par_out after reset", par_out, '0);
        check(busy == 1'b0, "R1 busy after reset", N'(busy), '0);

        // R2 and R5: one shift of a 1
        do_shift(1'b1, 0, bc);
        check(bc == 5, "R2 busy length", N'(bc), N'(5));
        check(par_out[0] == 1'b1, "R5 first stage captures ser_in", N'(par_out[0]), N'(1));
        check(par_out == model, "R6 single shift", par_out, model);

        // R6/R8: vector table
        for (int v = 0; v < NVEC; v++) begin
            for (int b = 15; b >= 0; b--) begin
                do_shift(VEC[v][b], 0, bc);
            end
            check(par_out == model, "R6 pattern history", par_out, model);
            check(ser_out == model[N-1], "R8 ser_out tracks last stage", N'(ser_out), N'(model[N-1]));
        end

        // R3: request held through busy period
        do_shift(1'b0, 3, bc);
        check(bc == 5, "R3 busy not extended by held request", N'(bc), N'(5));
        check(par_out == model, "R3 no extra shift", par_out, model);

        // R9: idle with toggling ser_in
        snap = par_out;
        snap_so = ser_out;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ser_in = ~ser_in;
        end
        @(negedge clk);
        check(par_out == snap, "R9 idle par_out stable", par_out, snap);
        check(ser_out == snap_so, "R9 idle ser_out stable", N'(ser_out), N'(snap_so));

        // R1: reset in the middle of a run
        do_reset();
        check(par_out == '0, "R1 mid-run reset clears", par_out, '0);

        // R7: a single one crossing the first boundary
        do_shift(1'b1, 0, bc);
        for (int i = 0; i < 3; i++) do_shift(1'b0, 0, bc);
        check(par_out == (N'(1) << 3), "R7 before boundary", par_out, N'(1) << 3);
        do_shift(1'b0, 0, bc);
        check(par_out == (N'(1) << 4), "R7 across boundary", par_out, N'(1) << 4);

        // R8: walk it to the serial output
        for (int i = 5; i < N; i++) do_shift(1'b0, 0, bc);
        check(ser_out == 1'b1, "R8 ser_out after N shifts", N'(ser_out), N'(1));
        check(par_out == model, "R6 walked one", par_out, model);
        do_shift(1'b0, 0, bc);
        check(ser_out == 1'b0, "R8 ser_out drained", N'(ser_out), N'(0));

        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule